// File: doc/BRIEF.md
# Triple-Copy Scan Comparator

This block watches three redundant copies of a circuit through three parallel scan chains, one chain per copy. On a capture strobe every chain loads its copy's observed signal vector (module and voter outputs, flip-flop inputs and outputs) in the same system clock cycle. The cells hold only this capture/shift stage and have no update latch, so the block sits beside the functional path and adds no delay to it.

A sequencer then issues shift strobes. Each accepted strobe moves `SHIFT_W` cells out of every chain at once. The heads of the three chains are compared lane by lane as they leave, and nothing is stored for later comparison. A lane where one copy disagrees with the other two names that copy as suspect. The block reports every step's verdict. It also keeps, for the whole pass, the first mismatching step and the copy blamed there, and it raises flags for a controller-region fault, for mismatches on consecutive steps, and for a step that blames more than one copy. The lowest cells of the observed vector leave the chain first. The sequencer places its own outputs there, so a mismatch in the first `CTRL_STEPS` steps marks the sequencer itself as faulty. With `CHAIN_LEN` cells and `SHIFT_W` lanes, a pass lasts `CHAIN_LEN/SHIFT_W` shift cycles. That length is the worst-case time to detect a fault.

Top module: `tri_scan_cmp`

## Requirements
- R1: After reset, every output is 0.
- R2: A cycle with `captureEn` high loads all three tap vectors, restarts the pass at step 0 and clears all pass results (`faultSeen`, `firstIndex`, `firstSuspect`, `ctrlFault`, `burstFault`, `multiFault`). Capture takes priority over a shift in the same cycle, and that shift is dropped.
- R3: Accepted shift number i of a pass (counting from 0) compares tap bits `[i*SHIFT_W +: SHIFT_W]`. Its result appears in the cycle after the strobe, with `cmpValid`=1 and `cmpIndex`=i. `cmpValid` is 0 in every cycle that does not follow an accepted shift.
- R4: `cmpSuspect` bit 0 names copy A, bit 1 copy B and bit 2 copy C. A bit is set when, in at least one lane of the step, that copy's bit differs from both other copies. `cmpMismatch` is 1 when `cmpSuspect` is nonzero.
- R5: `faultSeen` rises with the first mismatching step of a pass. `firstIndex` then holds that step's index and `firstSuspect` holds its suspect mask.
- R6: `ctrlFault` is set when a mismatch occurs at a step below `CTRL_STEPS` (default 2, which covers tap bits 0 to 3).
- R7: `burstFault` is set when two consecutive steps of a pass both mismatch.
- R8: `multiFault` is set when a single step blames more than one copy.
- R9: `scanDone` is a one-cycle pulse in the cycle after the last step's result is shown. Shift strobes after the last step are ignored until the next capture.
- R10: Pass results stay unchanged from the end of a pass until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| captureEn | input | 1 | Load all three chains from the taps |
| shiftEn | input | 1 | Shift and compare one step |
| tapA | input | CHAIN_LEN | Observed signals of copy A |
| tapB | input | CHAIN_LEN | Observed signals of copy B |
| tapC | input | CHAIN_LEN | Observed signals of copy C |
| cmpValid | output | 1 | A step result is shown this cycle |
| cmpIndex | output | IDX_W | Index of the step shown |
| cmpMismatch | output | 1 | The step shown has a disagreement |
| cmpSuspect | output | 3 | Copies blamed at the step shown (C,B,A) |
| faultSeen | output | 1 | A mismatch has occurred in this pass |
| firstIndex | output | IDX_W | Step index of the first mismatch |
| firstSuspect | output | 3 | Copies blamed at the first mismatch |
| ctrlFault | output | 1 | Mismatch within the sequencer region |
| burstFault | output | 1 | Mismatches on consecutive steps |
| multiFault | output | 1 | A step blamed more than one copy |
| scanDone | output | 1 | Pass complete pulse |

## Verification
A capture takes effect at the clock edge where it is sampled, so the pass results read 0 right after that edge. The result of a shift strobe is visible right after the edge that samples it, and the pass results include that step from the same edge. `scanDone` rises one edge later than the result of the final step. The bench drives each strobe for exactly one edge, samples one time unit after the edge, and checks each result against a model of the lane-compare rule. It also checks the idle cycles between strobes, the cycles after the final step, and the cycles where a capture coincides with a shift.

// File: rtl/tri_scan_pkg.sv
package tri_scan_pkg;
  // Strobes from the pass sequencer to the chain datapath
  typedef struct packed {
    logic load;      // capture taps into all chains
    logic shift;     // accepted shift-and-compare step
    logic ctrlStep;  // current step lies in the sequencer region
    logic lastStep;  // current step is the final one of the pass
  } scanStrobe_t;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import tri_scan_pkg::*;
#(
  parameter int STEPS      = 8,
  parameter int CTRL_STEPS = 2,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureEn,
  input  logic              shiftEn,
  output scanStrobe_t       strobe,
  output logic [IDX_W-1:0]  stepIdx,
  output logic              scanDone
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

  logic active;
  logic lastQ;

  always_comb begin
    strobe.load     = captureEn;
    strobe.shift    = shiftEn && active && !captureEn;
    strobe.ctrlStep = (32'(stepIdx) < CTRL_STEPS);
    strobe.lastStep = (stepIdx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      stepIdx  <= '0;
      lastQ    <= 1'b0;
      scanDone <= 1'b0;
    end else begin
      if (captureEn) begin
        active  <= 1'b1;
        stepIdx <= '0;
      end else if (strobe.shift) begin
        if (strobe.lastStep) begin
          active  <= 1'b0;
          stepIdx <= '0;
        end else begin
          stepIdx <= stepIdx + 1'b1;
        end
      end
      lastQ    <= strobe.shift && strobe.lastStep;
      scanDone <= lastQ;
    end
  end

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= LAST_IDX);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);
  assert_active_from_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(captureEn));
endmodule

// File: rtl/scan_lane_dp.sv
module scan_lane_dp
  import tri_scan_pkg::*;
#(
  parameter int CHAIN_LEN  = 16,
  parameter int SHIFT_W    = 2,
  parameter int CTRL_STEPS = 2,
  parameter int IDX_W      = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  scanStrobe_t           strobe,
  input  logic [IDX_W-1:0]      stepIdx,
  input  logic [CHAIN_LEN-1:0]  tapA,
  input  logic [CHAIN_LEN-1:0]  tapB,
  input  logic [CHAIN_LEN-1:0]  tapC,
  output logic                  cmpValid,
  output logic [IDX_W-1:0]      cmpIndex,
  output logic                  cmpMismatch,
  output logic [2:0]            cmpSuspect,
  output logic                  faultSeen,
  output logic [IDX_W-1:0]      firstIndex,
  output logic [2:0]            firstSuspect,
  output logic                  ctrlFault,
  output logic                  burstFault,
  output logic                  multiFault
);
  logic [CHAIN_LEN-1:0] tapArr   [3];
  logic [CHAIN_LEN-1:0] chainQ   [3];
  logic [SHIFT_W-1:0]   oddA, oddB, oddC;
  logic [2:0]           stepSuspect;
  logic                 stepMis;
  logic                 stepMulti;
  logic                 prevMis;

  assign tapArr[0] = tapA;
  assign tapArr[1] = tapB;
  assign tapArr[2] = tapC;

  // One capture/shift register per redundant copy
  for (genvar cp = 0; cp < 3; cp++) begin : g_chain
    always_ff @(posedge clk) begin
      if (!rstN)              chainQ[cp] <= '0;
      else if (strobe.load)   chainQ[cp] <= tapArr[cp];
      else if (strobe.shift)  chainQ[cp] <= chainQ[cp] >> SHIFT_W;
    end
  end

  // Lane-wise odd-one-out detection on the chain heads
  for (genvar ln = 0; ln < SHIFT_W; ln++) begin : g_lane
    logic hA, hB, hC;
    assign hA = chainQ[0][ln];
    assign hB = chainQ[1][ln];
    assign hC = chainQ[2][ln];
    assign oddA[ln] = (hA != hB) && (hA != hC);
    assign oddB[ln] = (hB != hA) && (hB != hC);
    assign oddC[ln] = (hC != hA) && (hC != hB);
  end

  always_comb begin
    stepSuspect = {|oddC, |oddB, |oddA};
    stepMis     = |stepSuspect;
    stepMulti   = ($countones(stepSuspect) > 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpValid     <= 1'b0;
      cmpIndex     <= '0;
      cmpMismatch  <= 1'b0;
      cmpSuspect   <= '0;
      faultSeen    <= 1'b0;
      firstIndex   <= '0;
      firstSuspect <= '0;
      ctrlFault    <= 1'b0;
      burstFault   <= 1'b0;
      multiFault   <= 1'b0;
      prevMis      <= 1'b0;
    end else if (strobe.load) begin
      cmpValid     <= 1'b0;
      cmpIndex     <= '0;
      cmpMismatch  <= 1'b0;
      cmpSuspect   <= '0;
      faultSeen    <= 1'b0;
      firstIndex   <= '0;
      firstSuspect <= '0;
      ctrlFault    <= 1'b0;
      burstFault   <= 1'b0;
      multiFault   <= 1'b0;
      prevMis      <= 1'b0;
    end else if (strobe.shift) begin
      cmpValid    <= 1'b1;
      cmpIndex    <= stepIdx;
      cmpMismatch <= stepMis;
      cmpSuspect  <= stepSuspect;
      prevMis     <= stepMis;
      if (stepMis && !faultSeen) begin
        faultSeen    <= 1'b1;
        firstIndex   <= stepIdx;
        firstSuspect <= stepSuspect;
      end
      if (stepMis && strobe.ctrlStep) ctrlFault  <= 1'b1;
      if (stepMis && prevMis)         burstFault <= 1'b1;
      if (stepMulti)                  multiFault <= 1'b1;
    end else begin
      cmpValid <= 1'b0;
    end
  end

  assert_valid_after_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |-> $past(strobe.shift));
  assert_first_on_mismatch_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultSeen) |-> (cmpMismatch && cmpIndex == firstIndex));
  assert_ctrl_early_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlFault) |-> (cmpMismatch && 32'(cmpIndex) < CTRL_STEPS));
  assert_multi_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(multiFault) |-> ($countones(cmpSuspect) > 1));
  assert_first_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (faultSeen && !strobe.load) |=> ($stable(firstIndex) && $stable(firstSuspect)));
endmodule

// File: rtl/tri_scan_cmp.sv
module tri_scan_cmp
  import tri_scan_pkg::*;
#(
  parameter int CHAIN_LEN  = 16,
  parameter int SHIFT_W    = 2,
  parameter int CTRL_STEPS = 2,
  localparam int STEPS     = CHAIN_LEN / SHIFT_W,
  localparam int IDX_W     = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  captureEn,
  input  logic                  shiftEn,
  input  logic [CHAIN_LEN-1:0]  tapA,
  input  logic [CHAIN_LEN-1:0]  tapB,
  input  logic [CHAIN_LEN-1:0]  tapC,
  output logic                  cmpValid,
  output logic [IDX_W-1:0]      cmpIndex,
  output logic                  cmpMismatch,
  output logic [2:0]            cmpSuspect,
  output logic                  faultSeen,
  output logic [IDX_W-1:0]      firstIndex,
  output logic [2:0]            firstSuspect,
  output logic                  ctrlFault,
  output logic                  burstFault,
  output logic                  multiFault,
  output logic                  scanDone
);
  scanStrobe_t      strobe;
  logic [IDX_W-1:0] stepIdx;

  scan_seq_ctrl #(
    .STEPS(STEPS), .CTRL_STEPS(CTRL_STEPS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .captureEn(captureEn), .shiftEn(shiftEn),
    .strobe(strobe), .stepIdx(stepIdx), .scanDone(scanDone)
  );

  scan_lane_dp #(
    .CHAIN_LEN(CHAIN_LEN), .SHIFT_W(SHIFT_W), .CTRL_STEPS(CTRL_STEPS), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx),
    .tapA(tapA), .tapB(tapB), .tapC(tapC),
    .cmpValid(cmpValid), .cmpIndex(cmpIndex), .cmpMismatch(cmpMismatch),
    .cmpSuspect(cmpSuspect), .faultSeen(faultSeen), .firstIndex(firstIndex),
    .firstSuspect(firstSuspect), .ctrlFault(ctrlFault), .burstFault(burstFault),
    .multiFault(multiFault)
  );
endmodule

// File: tb/tb_tri_scan_cmp.sv
module tb_tri_scan_cmp;
  localparam int LEN = 16;
  localparam int W   = 2;
  localparam int NST = LEN / W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic captureEn = 1'b0;
  logic shiftEn = 1'b0;
  logic [LEN-1:0] tapA = '0, tapB = '0, tapC = '0;
  logic cmpValid, cmpMismatch, faultSeen, ctrlFault, burstFault, multiFault, scanDone;
  logic [2:0] cmpIndex, firstIndex;
  logic [2:0] cmpSuspect, firstSuspect;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tri_scan_cmp dut (
    .clk(clk), .rstN(rstN), .captureEn(captureEn), .shiftEn(shiftEn),
    .tapA(tapA), .tapB(tapB), .tapC(tapC),
    .cmpValid(cmpValid), .cmpIndex(cmpIndex), .cmpMismatch(cmpMismatch),
    .cmpSuspect(cmpSuspect), .faultSeen(faultSeen), .firstIndex(firstIndex),
    .firstSuspect(firstSuspect), .ctrlFault(ctrlFault), .burstFault(burstFault),
    .multiFault(multiFault), .scanDone(scanDone)
  );

  typedef struct packed {
    logic [15:0] a, b, c;
    logic seen; logic [2:0] idx; logic [2:0] sus;
    logic ctrl, burst, multi;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'hA5C3, 16'hA5C3, 16'hA5C3, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 1'b0},
    '{16'h1234, 16'h1234, 16'h1334, 1'b1, 3'd4, 3'b100, 1'b0, 1'b0, 1'b0},
    '{16'h0F0F, 16'h0F0D, 16'h0F0F, 1'b1, 3'd0, 3'b010, 1'b1, 1'b0, 1'b0},
    '{16'h1C66, 16'h0866, 16'h0866, 1'b1, 3'd5, 3'b001, 1'b0, 1'b1, 1'b0},
    '{16'h00C0, 16'h0080, 16'h0000, 1'b1, 3'd3, 3'b101, 1'b0, 1'b0, 1'b1},
    '{16'h7FF8, 16'h3FF0, 16'h3FF0, 1'b1, 3'd1, 3'b001, 1'b1, 1'b0, 1'b0}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Suspect mask of step i per R4 rule
  function automatic logic [2:0] modelSus(logic [15:0] a, logic [15:0] b, logic [15:0] c, int i);
    logic [2:0] m = '0;
    for (int l = 0; l < W; l++) begin
      logic x, y, z;
      x = a[i*W+l]; y = b[i*W+l]; z = c[i*W+l];
      if (x != y && x != z) m[0] = 1'b1;
      if (y != x && y != z) m[1] = 1'b1;
      if (z != x && z != y) m[2] = 1'b1;
    end
    return m;
  endfunction

  task automatic capture(logic [15:0] a, logic [15:0] b, logic [15:0] c);
    tapA = a; tapB = b; tapC = c; captureEn = 1'b1;
    step();
    captureEn = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 cmpValid", int'(cmpValid), 0);
    chk("R1 faultSeen", int'(faultSeen), 0);
    chk("R1 flags", int'({ctrlFault, burstFault, multiFault, scanDone}), 0);
    rstN = 1'b1;
    step();
    chk("R1 after release", int'({cmpValid, faultSeen, scanDone}), 0);

    // Vector table walk
    for (int v = 0; v < 6; v++) begin
      capture(VECS[v].a, VECS[v].b, VECS[v].c);
      chk("R2 cleared", int'({faultSeen, ctrlFault, burstFault, multiFault}), 0);
      for (int i = 0; i < NST; i++) begin
        shiftEn = 1'b1;
        step();
        chk("R3 cmpValid", int'(cmpValid), 1);
        chk("R3 cmpIndex", int'(cmpIndex), i);
        chk("R4 cmpSuspect", int'(cmpSuspect), int'(modelSus(VECS[v].a, VECS[v].b, VECS[v].c, i)));
        chk("R4 cmpMismatch", int'(cmpMismatch), int'(modelSus(VECS[v].a, VECS[v].b, VECS[v].c, i) != 0));
        chk("R9 no early done", int'(scanDone), 0);
      end
      shiftEn = 1'b0;
      step();
      chk("R9 scanDone pulse", int'(scanDone), 1);
      chk("R3 idle cmpValid", int'(cmpValid), 0);
      chk("R5 faultSeen", int'(faultSeen), int'(VECS[v].seen));
      chk("R5 firstIndex", int'(firstIndex), int'(VECS[v].idx));
      chk("R5 firstSuspect", int'(firstSuspect), int'(VECS[v].sus));
      chk("R6 ctrlFault", int'(ctrlFault), int'(VECS[v].ctrl));
      chk("R7 burstFault", int'(burstFault), int'(VECS[v].burst));
      chk("R8 multiFault", int'(multiFault), int'(VECS[v].multi));
      step();
      chk("R9 scanDone one cycle", int'(scanDone), 0);
      // R9/R10: extra shift after pass end is ignored, results held
      shiftEn = 1'b1;
      step();
      shiftEn = 1'b0;
      chk("R9 ignored shift", int'(cmpValid), 0);
      chk("R10 held firstIndex", int'(firstIndex), int'(VECS[v].idx));
      chk("R10 held multi", int'(multiFault), int'(VECS[v].multi));
      step();
      chk("R9 no second done", int'(scanDone), 0);
    end

    // R2: capture wins over simultaneous shift
    tapA = 16'h0001; tapB = 16'h0000; tapC = 16'h0000;
    captureEn = 1'b1; shiftEn = 1'b1;
    step();
    captureEn = 1'b0; shiftEn = 1'b0;
    chk("R2 shift dropped", int'(cmpValid), 0);
    shiftEn = 1'b1;
    step();
    shiftEn = 1'b0;
    chk("R2 restart index", int'(cmpIndex), 0);
    chk("R2 step0 suspect", int'(cmpSuspect), 1);
    // R3: gap cycle shows no result
    step();
    chk("R3 gap cmpValid", int'(cmpValid), 0);
    chk("R10 held mid-pass", int'(faultSeen), 1);
    // R2: mid-pass capture clears results
    capture(16'h5555, 16'h5555, 16'h5555);
    chk("R2 recapture clears", int'({faultSeen, ctrlFault, firstSuspect}), 0);
    shiftEn = 1'b1;
    step();
    shiftEn = 1'b0;
    chk("R3 recapture index", int'(cmpIndex), 0);
    chk("R4 clean step", int'(cmpMismatch), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule